// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit resolves the source operand of an accumulator load. A caller supplies a 4-bit mode code, the instruction's address field, the already-advanced program counter, the index register, a base register and the value of one selected general register, all valid in the single cycle in which `start_i` is high. The unit forms the effective address, makes zero, one or two reads through a synchronous memory port with one cycle of read latency, and returns the operand and effective address on a one-cycle `done_o` pulse.

For the two self-modifying register modes it also returns a write-back value for the selected register. For post-increment the value is the old register plus one. For pre-decrement the value is the old register minus one, and that decremented value is also the address that is read. All fetches share one small sequencer, so the unit handles one fetch at a time. A `start_i` raised while a fetch is in flight is dropped.

Top module: `opfetch_unit`

## Requirements
- R1: While reset is asserted and up to the first start, `done_o`, `mem_rd_o` and `reg_we_o` are low.
- R2: In every single-read mode, exactly one read is issued. The read is issued in the cycle after the start edge, and `done_o` is high in the third cycle after the start edge.
- R3: Mode 1 (immediate) returns the address field as the operand with `ea_o` = 0, makes no read, and raises `done_o` in the first cycle after the start edge.
- R4: Mode 2 (indirect) issues a first read at the address field and a second read at the word returned by the first. The operand is the word returned by the second read, `ea_o` is the pointer word, and `done_o` is high in the fifth cycle after the start edge.
- R5: The effective address is computed as follows, and the operand is the memory word at that address. Mode 0 (direct) uses the address field. Mode 3 (PC-relative) uses PC plus the field. Mode 4 (indexed) uses index plus the field. Mode 5 (base) uses base plus the field. All sums wrap modulo 2^W.
- R6: Mode 6 (register) returns the register value as the operand with `ea_o` = 0, makes no read, and raises `done_o` in the first cycle after the start edge.
- R7: Mode 7 (register indirect) and mode 8 (post-increment) use the register value as the effective address. Mode 9 (pre-decrement) uses the register value minus one. Modes 8 and 9 raise `reg_we_o` with `done_o` and return the register value plus one or minus one respectively on `reg_wdata_o`. No other mode raises `reg_we_o`.
- R8: Mode codes 10 to 15 return operand 0 and `ea_o` 0, make no read and no write-back, and raise `done_o` in the first cycle after the start edge.
- R9: `done_o` lasts exactly one cycle. `operand_o` and `ea_o` hold their values until the next completion.
- R10: A `start_i` pulse while a fetch is in progress is ignored. It produces no extra read and no extra `done_o`.
- R11: Mode, field and register inputs are sampled only in the start cycle. Changing them afterwards does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a fetch; other inputs valid this cycle |
| mode_i | input | 4 | Addressing-mode code |
| field_i | input | W | Address field of the instruction |
| pc_i | input | W | Program counter, already past the instruction |
| idx_i | input | W | Index register value |
| base_i | input | W | Base register value |
| reg_i | input | W | Selected general register value |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | W | Memory read address |
| mem_rdata_i | input | W | Read data, one cycle after the strobe |
| done_o | output | 1 | Fetch complete pulse |
| operand_o | output | W | Fetched operand |
| ea_o | output | W | Effective address |
| reg_we_o | output | 1 | General register write-back strobe |
| reg_wdata_o | output | W | General register write-back value |

## Verification
A corrupted sequencer state shows at the ports within one to four cycles in one of three ways: a read strobe where none belongs, a missing or late `done_o`, or a second read in an indirect fetch aimed at something other than the pointer word. Each of these is caught by measuring latency and the number and address of reads on every fetch. A wrong latched address or write-back value shows up as a wrong `ea_o`, operand or `reg_wdata_o` on the very `done_o` pulse of that fetch. Sweeping all sixteen codes over several operand patterns, with memory contents given by an arithmetic function, exposes any decode slip on the fetch where it occurs.

// File: rtl/opf_pkg.sv
package opf_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_DIRECT  = 4'd0,
    MODE_IMM     = 4'd1,
    MODE_IND     = 4'd2,
    MODE_PCREL   = 4'd3,
    MODE_IDX     = 4'd4,
    MODE_BASE    = 4'd5,
    MODE_REG     = 4'd6,
    MODE_REGIND  = 4'd7,
    MODE_POSTINC = 4'd8,
    MODE_PREDEC  = 4'd9
  } mode_e;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_ONE,
    ACC_TWO
  } access_e;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_PC,
    SRC_IDX,
    SRC_BASE,
    SRC_REG,
    SRC_REGM1
  } src_e;

  typedef enum logic [1:0] {
    IMM_ZERO,
    IMM_FIELD,
    IMM_REG
  } imm_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR_RD,
    ST_PTR_WAIT,
    ST_OP_RD,
    ST_OP_WAIT
  } state_e;

  typedef struct packed {
    access_e access;
    src_e    src;
    logic    add_field;
    imm_e    imm;
    logic    wb_en;
    logic    wb_dec;
  } ctrl_t;

endpackage

// File: rtl/opf_mode_dec.sv
module opf_mode_dec
  import opf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output ctrl_t             ctrl_o
);

  always_comb begin
    ctrl_o.access    = ACC_NONE;
    ctrl_o.src       = SRC_ZERO;
    ctrl_o.add_field = 1'b0;
    ctrl_o.imm       = IMM_ZERO;
    ctrl_o.wb_en     = 1'b0;
    ctrl_o.wb_dec    = 1'b0;
    case (mode_i)
      MODE_DIRECT: begin
        ctrl_o.access    = ACC_ONE;
        ctrl_o.add_field = 1'b1;
      end
      MODE_IMM: begin
        ctrl_o.imm = IMM_FIELD;
      end
      MODE_IND: begin
        ctrl_o.access    = ACC_TWO;
        ctrl_o.add_field = 1'b1;
      end
      MODE_PCREL: begin
        ctrl_o.access    = ACC_ONE;
        ctrl_o.src       = SRC_PC;
        ctrl_o.add_field = 1'b1;
      end
      MODE_IDX: begin
        ctrl_o.access    = ACC_ONE;
        ctrl_o.src       = SRC_IDX;
        ctrl_o.add_field = 1'b1;
      end
      MODE_BASE: begin
        ctrl_o.access    = ACC_ONE;
        ctrl_o.src       = SRC_BASE;
        ctrl_o.add_field = 1'b1;
      end
      MODE_REG: begin
        ctrl_o.imm = IMM_REG;
      end
      MODE_REGIND: begin
        ctrl_o.access = ACC_ONE;
        ctrl_o.src    = SRC_REG;
      end
      MODE_POSTINC: begin
        ctrl_o.access = ACC_ONE;
        ctrl_o.src    = SRC_REG;
        ctrl_o.wb_en  = 1'b1;
      end
      MODE_PREDEC: begin
        ctrl_o.access = ACC_ONE;
        ctrl_o.src    = SRC_REGM1;
        ctrl_o.wb_en  = 1'b1;
        ctrl_o.wb_dec = 1'b1;
      end
      default: begin
        ctrl_o.access = ACC_NONE;
      end
    endcase
  end

  // R7: write-back is only ever requested by single-read register modes
  always_comb begin
    assert_wb_single_R7: assert (!ctrl_o.wb_en || (ctrl_o.access == ACC_ONE && ctrl_o.src inside {SRC_REG, SRC_REGM1}));
  end

endmodule

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
  import opf_pkg::*;
#(
  parameter int W = 12
) (
  input  ctrl_t          ctrl_i,
  input  logic [W-1:0]   field_i,
  input  logic [W-1:0]   pc_i,
  input  logic [W-1:0]   idx_i,
  input  logic [W-1:0]   base_i,
  input  logic [W-1:0]   reg_i,
  output logic [W-1:0]   addr_o,
  output logic [W-1:0]   imm_o,
  output logic [W-1:0]   wb_val_o
);

  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] reg_inc;
  logic [W-1:0] reg_dec;
  logic [W-1:0] base_val;
  logic [W-1:0] offset;

  assign reg_inc = reg_i + STEP;
  assign reg_dec = reg_i - STEP;

  always_comb begin
    case (ctrl_i.src)
      SRC_PC:    base_val = pc_i;
      SRC_IDX:   base_val = idx_i;
      SRC_BASE:  base_val = base_i;
      SRC_REG:   base_val = reg_i;
      SRC_REGM1: base_val = reg_dec;
      default:   base_val = '0;
    endcase
  end

  assign offset = ctrl_i.add_field ? field_i : '0;
  assign addr_o = base_val + offset;

  always_comb begin
    case (ctrl_i.imm)
      IMM_FIELD: imm_o = field_i;
      IMM_REG:   imm_o = reg_i;
      default:   imm_o = '0;
    endcase
  end

  assign wb_val_o = ctrl_i.wb_dec ? reg_dec : reg_inc;

  // R7: pre-decrement address and its write-back value are the same word
  always_comb begin
    if (ctrl_i.src == SRC_REGM1 && ctrl_i.wb_en) begin
      assert_predec_match_R7: assert (addr_o == wb_val_o);
    end
  end

endmodule

// File: rtl/opf_seq.sv
module opf_seq
  import opf_pkg::*;
#(
  parameter int W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  access_e       access_i,
  input  logic [W-1:0]  first_addr_i,
  input  logic [W-1:0]  imm_val_i,
  input  logic          wb_en_i,
  input  logic [W-1:0]  wb_val_i,
  output logic          mem_rd_o,
  output logic [W-1:0]  mem_addr_o,
  input  logic [W-1:0]  mem_rdata_i,
  output logic          done_o,
  output logic [W-1:0]  operand_o,
  output logic [W-1:0]  ea_o,
  output logic          reg_we_o,
  output logic [W-1:0]  reg_wdata_o
);

  state_e       state_q, state_d;
  logic [W-1:0] addr_q, addr_d;
  logic         wb_en_q, wb_en_d;
  logic [W-1:0] wb_val_q, wb_val_d;
  logic         done_q, done_d;
  logic [W-1:0] operand_q, operand_d;
  logic [W-1:0] ea_q, ea_d;
  logic         we_q, we_d;
  logic [W-1:0] wdata_q, wdata_d;
  logic         take;

  assign take = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    wb_en_d   = wb_en_q;
    wb_val_d  = wb_val_q;
    done_d    = 1'b0;
    operand_d = operand_q;
    ea_d      = ea_q;
    we_d      = 1'b0;
    wdata_d   = wdata_q;
    case (state_q)
      ST_IDLE: begin
        if (take) begin
          wb_en_d  = wb_en_i;
          wb_val_d = wb_val_i;
          addr_d   = first_addr_i;
          case (access_i)
            ACC_ONE: state_d = ST_OP_RD;
            ACC_TWO: state_d = ST_PTR_RD;
            default: begin
              done_d    = 1'b1;
              operand_d = imm_val_i;
              ea_d      = '0;
            end
          endcase
        end
      end
      ST_PTR_RD:   state_d = ST_PTR_WAIT;
      ST_PTR_WAIT: begin
        addr_d  = mem_rdata_i;
        state_d = ST_OP_RD;
      end
      ST_OP_RD:    state_d = ST_OP_WAIT;
      ST_OP_WAIT: begin
        operand_d = mem_rdata_i;
        ea_d      = addr_q;
        done_d    = 1'b1;
        we_d      = wb_en_q;
        wdata_d   = wb_val_q;
        state_d   = ST_IDLE;
      end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wb_en_q   <= 1'b0;
      wb_val_q  <= '0;
      done_q    <= 1'b0;
      operand_q <= '0;
      ea_q      <= '0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
    end else begin
      state_q   <= state_d;
      addr_q    <= addr_d;
      wb_en_q   <= wb_en_d;
      wb_val_q  <= wb_val_d;
      done_q    <= done_d;
      operand_q <= operand_d;
      ea_q      <= ea_d;
      we_q      <= we_d;
      wdata_q   <= wdata_d;
    end
  end

  assign mem_rd_o    = (state_q == ST_PTR_RD) || (state_q == ST_OP_RD);
  assign mem_addr_o  = addr_q;
  assign done_o      = done_q;
  assign operand_o   = operand_q;
  assign ea_o        = ea_q;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_read_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> (!mem_rd_o && !done_o));

  assert_read_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OP_WAIT) |=> (done_o && operand_o == $past(mem_rdata_i)));

  assert_ptr_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PTR_WAIT) |=> (mem_rd_o && mem_addr_o == $past(mem_rdata_i)));

  assert_nomem_quick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && access_i == ACC_NONE) |=> (done_o && !mem_rd_o && operand_o == $past(imm_val_i)));

  assert_wb_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> done_o);

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_OP_WAIT) |=> !done_o);

endmodule

// File: rtl/opfetch_unit.sv
module opfetch_unit
  import opf_pkg::*;
#(
  parameter int W           = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [W-1:0]      field_i,
  input  logic [W-1:0]      pc_i,
  input  logic [W-1:0]      idx_i,
  input  logic [W-1:0]      base_i,
  input  logic [W-1:0]      reg_i,
  output logic              mem_rd_o,
  output logic [W-1:0]      mem_addr_o,
  input  logic [W-1:0]      mem_rdata_i,
  output logic              done_o,
  output logic [W-1:0]      operand_o,
  output logic [W-1:0]      ea_o,
  output logic              reg_we_o,
  output logic [W-1:0]      reg_wdata_o
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  ctrl_t        ctrl;
  logic [W-1:0] first_addr;
  logic [W-1:0] imm_val;
  logic [W-1:0] wb_val;

  opf_mode_dec u_dec (
    .mode_i (mode_i),
    .ctrl_o (ctrl)
  );

  opf_ea_calc #(.W(W)) u_ea (
    .ctrl_i   (ctrl),
    .field_i  (field_i),
    .pc_i     (pc_i),
    .idx_i    (idx_i),
    .base_i   (base_i),
    .reg_i    (reg_i),
    .addr_o   (first_addr),
    .imm_o    (imm_val),
    .wb_val_o (wb_val)
  );

  opf_seq #(.W(W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .access_i     (ctrl.access),
    .first_addr_i (first_addr),
    .imm_val_i    (imm_val),
    .wb_en_i      (ctrl.wb_en),
    .wb_val_i     (wb_val),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rdata_i  (mem_rdata_i),
    .done_o       (done_o),
    .operand_o    (operand_o),
    .ea_o         (ea_o),
    .reg_we_o     (reg_we_o),
    .reg_wdata_o  (reg_wdata_o)
  );

  // R1: nothing leaves the block while the internal reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_int_n |-> (!done_o && !mem_rd_o && !reg_we_o));

endmodule

// File: tb/opfetch_unit_tb_top.sv
module opfetch_unit_tb_top;

  localparam int W = 12;
  localparam logic [W-1:0] MASK = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [3:0]   mode;
  logic [W-1:0] field, pc_v, idx_v, base_v, reg_v;
  logic         mem_rd;
  logic [W-1:0] mem_addr;
  logic [W-1:0] mem_rdata;
  logic         done;
  logic [W-1:0] operand, ea;
  logic         reg_we;
  logic [W-1:0] reg_wdata;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  opfetch_unit #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
    .field_i(field), .pc_i(pc_v), .idx_i(idx_v), .base_i(base_v), .reg_i(reg_v),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .done_o(done), .operand_o(operand), .ea_o(ea),
    .reg_we_o(reg_we), .reg_wdata_o(reg_wdata)
  );

  function automatic logic [W-1:0] memf(input logic [W-1:0] a);
    return W'((int'(a) * 13 + 1445) & int'(MASK));
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= memf(mem_addr);
  end

  task automatic check(input bit ok, input string tg, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tg, what, act, exp);
    end
  endtask

  task automatic run_fetch(input logic [3:0] m, input logic [W-1:0] f, input logic [W-1:0] pc,
                           input logic [W-1:0] ix, input logic [W-1:0] bs, input logic [W-1:0] rg);
    logic [W-1:0] e_ea, e_op, e_a1, e_wd, a1, a2, op_seen, ea_seen;
    int e_lat, e_nr, n, nr;
    logic e_we, got;
    string tg;
    e_ea = '0; e_op = '0; e_a1 = '0; e_wd = '0; e_we = 1'b0; e_lat = 1; e_nr = 0;
    a1 = '0; a2 = '0;
    case (m)
      4'd0: begin tg = "R5"; e_ea = f; end
      4'd1: begin tg = "R3"; e_op = f; end
      4'd2: begin tg = "R4"; e_ea = memf(f); e_a1 = f; e_nr = 2; e_lat = 5; e_op = memf(e_ea); end
      4'd3: begin tg = "R5"; e_ea = pc + f; end
      4'd4: begin tg = "R5"; e_ea = ix + f; end
      4'd5: begin tg = "R5"; e_ea = bs + f; end
      4'd6: begin tg = "R6"; e_op = rg; end
      4'd7: begin tg = "R7"; e_ea = rg; end
      4'd8: begin tg = "R7"; e_ea = rg; e_we = 1'b1; e_wd = rg + 1'b1; end
      4'd9: begin tg = "R7"; e_ea = rg - 1'b1; e_we = 1'b1; e_wd = rg - 1'b1; end
      default: begin tg = "R8"; end
    endcase
    if (m == 4'd0 || (m >= 4'd3 && m <= 4'd5) || (m >= 4'd7 && m <= 4'd9)) begin
      e_nr = 1; e_lat = 3; e_a1 = e_ea; e_op = memf(e_ea);
    end
    @(negedge clk);
    start = 1'b1; mode = m; field = f; pc_v = pc; idx_v = ix; base_v = bs; reg_v = rg;
    @(negedge clk);
    // R11: scramble every input once the start cycle is over
    start = 1'b0; mode = ~m; field = ~f; pc_v = ~pc; idx_v = ~ix; base_v = ~bs; reg_v = ~rg;
    n = 1; nr = 0; got = 1'b0;
    while (!got && n < 12) begin
      if (mem_rd) begin
        if (nr == 0) a1 = mem_addr; else a2 = mem_addr;
        if (nr == 0) check(n == 1, "R2", "first read cycle", W'(n), W'(1));
        nr++;
      end
      if (done) got = 1'b1;
      else begin
        @(negedge clk);
        n++;
      end
    end
    check(got && n == e_lat, e_nr == 1 ? "R2" : tg, "done latency", W'(n), W'(e_lat));
    check(nr == e_nr, e_nr == 1 ? "R2" : tg, "read count", W'(nr), W'(e_nr));
    if (e_nr > 0) check(a1 == e_a1, tg, "first read addr", a1, e_a1);
    if (e_nr == 2) check(a2 == e_ea, "R4", "pointer read addr", a2, e_ea);
    check(operand == e_op, {tg, "/R11"}, "operand", operand, e_op);
    check(ea == e_ea, {tg, "/R11"}, "ea", ea, e_ea);
    check(reg_we == e_we, "R7", "write-back strobe", W'(reg_we), W'(e_we));
    if (e_we) check(reg_wdata == e_wd, "R7", "write-back value", reg_wdata, e_wd);
    op_seen = operand; ea_seen = ea;
    @(negedge clk);
    check(!done, "R9", "done width", W'(done), W'(0));
    check(operand == op_seen && ea == ea_seen, "R9", "operand hold", operand, op_seen);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = '0; field = '0;
    pc_v = '0; idx_v = '0; base_v = '0; reg_v = '0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    check(!done && !mem_rd && !reg_we, "R1", "outputs in reset", W'({done, mem_rd, reg_we}), W'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && !mem_rd && !reg_we, "R1", "outputs after reset", W'({done, mem_rd, reg_we}), W'(0));

    // worked examples: PC past a two-word instruction, register at 400
    run_fetch(4'd3, W'(500), W'(202), W'(100), W'(0), W'(400));
    check(ea == W'(702), "R5", "relative example ea", ea, W'(702));
    run_fetch(4'd9, W'(500), W'(202), W'(100), W'(0), W'(400));
    check(ea == W'(399), "R7", "pre-decrement example ea", ea, W'(399));
    run_fetch(4'd8, W'(500), W'(202), W'(100), W'(0), W'(400));
    run_fetch(4'd4, W'(500), W'(202), W'(100), W'(0), W'(400));

    // wrap corners
    run_fetch(4'd9, W'(7), W'(0), W'(0), W'(0), W'(0));
    run_fetch(4'd8, W'(7), W'(0), W'(0), W'(0), MASK);
    run_fetch(4'd5, MASK, W'(0), W'(0), W'(2), W'(0));

    // sweep of every code over several operand patterns
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 16; m++) begin
        run_fetch(4'(m), W'((p * 677 + 5) & int'(MASK)), W'((p * 311 + 2) & int'(MASK)),
                  W'((p * 97 + 40) & int'(MASK)), W'((p * 1201 + 9) & int'(MASK)),
                  W'((p * 523 + 1) & int'(MASK)));
      end
    end

    // R10: a second start during an indirect fetch must be dropped
    begin
      int dones, reads;
      logic [W-1:0] ptr;
      ptr = memf(W'(33));
      @(negedge clk);
      start = 1'b1; mode = 4'd2; field = W'(33);
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      start = 1'b1; mode = 4'd1; field = W'(999);
      @(negedge clk);
      start = 1'b0;
      dones = 0; reads = 1;
      for (int c = 0; c < 10; c++) begin
        if (mem_rd) reads++;
        if (done) begin
          dones++;
          check(operand == memf(ptr), "R10", "operand of first fetch", operand, memf(ptr));
        end
        @(negedge clk);
      end
      check(dones == 1, "R10", "done count", W'(dones), W'(1));
      check(reads == 2, "R10", "read count", W'(reads), W'(2));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule